// File: doc/BRIEF.md
# Threshold-Quantizing Key Filter for Power-Up Memory Fingerprints

The block turns the raw power-up contents of an on-chip memory into a binary key that reads the same on every power-up. The raw stream arrives as words. It is cut into samples of `SAMPLE_W` bits, and the ones in each sample are counted. Each count yields one key bit: 1 when the count is at least half the sample width, 0 otherwise. Counts that fall inside a band of `VOL_W` values centred on that midpoint are unreliable, and their key positions are called volatile.

On a part's first power-up the block learns where the volatile positions are. The one-time-programmable (OTP) store holds a write flag, and while that flag is clear the block writes the map of volatile positions into the store and sets the flag. On every later power-up it reads the stored map back. The map is fetched while the raw words are still streaming in, and the block then forces the marked key positions to a fixed value chosen by the parameter `FIX_ONE`. The key is published with a one-cycle done strobe and held until the next run. The memory, the OTP macro and any cryptography that uses the key lie outside the block.

The controller has four states:
- `ST_IDLE`: waits for `start`. On `start` it issues the OTP read and moves to `ST_COLLECT`.
- `ST_COLLECT`: takes one raw word per `raw_valid`. After the last word it moves to `ST_MERGE` if the OTP data has arrived, otherwise to `ST_WAIT_OTP`.
- `ST_WAIT_OTP`: waits for `otp_rd_valid`, then moves to `ST_MERGE`.
- `ST_MERGE`: lasts one cycle. It applies the mask, writes the OTP if the flag is clear, and returns to `ST_IDLE`.

Top module: `puf_qfilter`

## Requirements
- R1: While reset is held and right after it is released, `key_out` is 0 and `key_done`, `otp_rd_en` and `otp_wr_en` are low.
- R2: Bit b of raw word k is bit k*`WORD_W`+b of the raw stream. Stream bits [i*`SAMPLE_W` +: `SAMPLE_W`] form sample i, and sample i produces key bit i.
- R3: A key bit is 1 when its sample's ones-count is at least `SAMPLE_W`/2, and 0 when the count is lower.
- R4: A position is volatile when its count lies in [`SAMPLE_W`/2-(`VOL_W`-1)/2, `SAMPLE_W`/2+(`VOL_W`-1)/2]. With the defaults this is counts 3 to 5. The learned map holds a 1 at each volatile position.
- R5: When the stored flag is clear, `otp_wr_en` pulses exactly once per run, with `otp_wr_flag`=1 and `otp_wr_map` equal to the learned map. The pulse comes in the cycle before `key_done`, and the key is masked with the learned map.
- R6: When the stored flag is set, `otp_wr_en` never rises, and the key is masked with the stored map whatever the raw data is.
- R7: With `FIX_ONE`=0 the output is key AND NOT mask. With `FIX_ONE`=1 it is key OR mask.
- R8: `key_done` is a single-cycle pulse. It comes two cycles after the later of two cycles: the cycle that accepts the last raw word, and the cycle that accepts the OTP read data.
- R9: `key_out` changes only together with `key_done`. Raw words offered outside `ST_COLLECT` are ignored.
- R10: `otp_rd_en` pulses for one cycle when `start` is seen in `ST_IDLE`. A `start` during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a filtering run |
| raw_valid | input | 1 | Raw word present |
| raw_word | input | WORD_W | Raw power-up data word |
| otp_rd_en | output | 1 | OTP read request |
| otp_rd_valid | input | 1 | OTP read data present |
| otp_rd_flag | input | 1 | Stored write flag |
| otp_rd_map | input | KEY_LEN | Stored volatile map |
| otp_wr_en | output | 1 | OTP write strobe |
| otp_wr_flag | output | 1 | Flag value to program |
| otp_wr_map | output | KEY_LEN | Map value to program |
| key_out | output | KEY_LEN | Filtered key |
| key_done | output | 1 | Key-ready pulse |

## Verification
The assertions assume the OTP answers each read exactly once, with `otp_rd_valid` appearing only after `otp_rd_en` and before the run ends. They also assume `raw_valid` carries exactly the number of words one key needs. The stimulus follows these rules: one OTP response per run, and exactly the required words, with gaps only between them. Stray raw words are offered only outside the collection window, and extra `start` pulses only during a run, which exercises the ignore paths without breaking the assumptions.

// File: rtl/puf_qf_pkg.sv
package puf_qf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_WAIT_OTP,
        ST_MERGE
    } qf_state_t;
endpackage

// File: rtl/puf_qf_lane.sv
module puf_qf_lane #(
    parameter int SAMPLE_W = 8,
    parameter int VOL_W    = 3
) (
    input  logic [SAMPLE_W-1:0] sample,
    output logic                key_bit,
    output logic                vol_bit
);
    localparam int WT_W = $clog2(SAMPLE_W + 1);
    localparam int QTH  = SAMPLE_W / 2;
    localparam int HALF = (VOL_W - 1) / 2;
    localparam int LO   = QTH - HALF;
    localparam int HI   = QTH + HALF;

    logic [WT_W-1:0] weight;

    always_comb begin
        weight = '0;
        for (int i = 0; i < SAMPLE_W; i++) begin
            weight = weight + WT_W'(sample[i]);
        end
    end

    assign key_bit = (int'(weight) >= QTH);
    assign vol_bit = (int'(weight) >= LO) && (int'(weight) <= HI);
endmodule

// File: rtl/puf_qf_ctrl.sv
module puf_qf_ctrl
    import puf_qf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      raw_valid,
    input  logic      last_word,
    input  logic      otp_rd_valid,
    input  logic      otp_got,
    input  logic      stored_flag,
    output qf_state_t state,
    output logic      otp_rd_en,
    output logic      take_word,
    output logic      take_otp,
    output logic      merge,
    output logic      otp_wr_en
);
    qf_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (start) nxt = ST_COLLECT;
            ST_COLLECT:  if (raw_valid && last_word)
                             nxt = (otp_got || otp_rd_valid) ? ST_MERGE : ST_WAIT_OTP;
            ST_WAIT_OTP: if (otp_rd_valid) nxt = ST_MERGE;
            ST_MERGE:    nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        otp_rd_en = (state == ST_IDLE) && start;
        take_word = (state == ST_COLLECT) && raw_valid;
        take_otp  = ((state == ST_COLLECT) || (state == ST_WAIT_OTP)) && otp_rd_valid;
        merge     = (state == ST_MERGE);
        otp_wr_en = (state == ST_MERGE) && !stored_flag;
    end

    // R8
    merge_needs_otp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MERGE) |-> otp_got);
    // R10
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        otp_rd_en |=> !otp_rd_en);
endmodule

// File: rtl/puf_qfilter.sv
module puf_qfilter
    import puf_qf_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int VOL_W    = 3,
    parameter int KEY_LEN  = 16,
    parameter int WORD_W   = 32,
    parameter bit FIX_ONE  = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               raw_valid,
    input  logic [WORD_W-1:0]  raw_word,
    output logic               otp_rd_en,
    input  logic               otp_rd_valid,
    input  logic               otp_rd_flag,
    input  logic [KEY_LEN-1:0] otp_rd_map,
    output logic               otp_wr_en,
    output logic               otp_wr_flag,
    output logic [KEY_LEN-1:0] otp_wr_map,
    output logic [KEY_LEN-1:0] key_out,
    output logic               key_done
);
    localparam int LANES  = WORD_W / SAMPLE_W;
    localparam int NWORDS = KEY_LEN / LANES;
    localparam int CNT_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;

    qf_state_t          state;
    logic               take_word, take_otp, merge, last_word;
    logic [CNT_W-1:0]   word_cnt;
    logic [LANES-1:0]   lane_key, lane_vol;
    logic [KEY_LEN-1:0] key_q, vmap_q, otp_map_q, mask;
    logic               otp_flag_q, otp_got_q;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            puf_qf_lane #(.SAMPLE_W(SAMPLE_W), .VOL_W(VOL_W)) u_lane (
                .sample  (raw_word[g*SAMPLE_W +: SAMPLE_W]),
                .key_bit (lane_key[g]),
                .vol_bit (lane_vol[g])
            );
        end
    endgenerate

    assign last_word = (word_cnt == CNT_W'(NWORDS - 1));

    puf_qf_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .raw_valid    (raw_valid),
        .last_word    (last_word),
        .otp_rd_valid (otp_rd_valid),
        .otp_got      (otp_got_q),
        .stored_flag  (otp_flag_q),
        .state        (state),
        .otp_rd_en    (otp_rd_en),
        .take_word    (take_word),
        .take_otp     (take_otp),
        .merge        (merge),
        .otp_wr_en    (otp_wr_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_cnt <= '0;
            key_q    <= '0;
            vmap_q   <= '0;
        end else if (otp_rd_en) begin
            word_cnt <= '0;
        end else if (take_word) begin
            word_cnt <= last_word ? '0 : word_cnt + 1'b1;
            key_q    <= {lane_key, key_q[KEY_LEN-1:LANES]};
            vmap_q   <= {lane_vol, vmap_q[KEY_LEN-1:LANES]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            otp_got_q  <= 1'b0;
            otp_flag_q <= 1'b0;
            otp_map_q  <= '0;
        end else if (otp_rd_en) begin
            otp_got_q <= 1'b0;
        end else if (take_otp) begin
            otp_got_q  <= 1'b1;
            otp_flag_q <= otp_rd_flag;
            otp_map_q  <= otp_rd_map;
        end
    end

    assign mask        = otp_flag_q ? otp_map_q : vmap_q;
    assign otp_wr_flag = otp_wr_en;
    assign otp_wr_map  = vmap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_out  <= '0;
            key_done <= 1'b0;
        end else begin
            key_done <= merge;
            if (merge) key_out <= FIX_ONE ? (key_q | mask) : (key_q & ~mask);
        end
    end

    // R6
    otp_wr_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        otp_wr_en |-> !otp_flag_q);
    // R5
    wr_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        otp_wr_en |=> key_done);
    // R9
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(key_out) |-> key_done);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_done |=> !key_done);
endmodule

// File: tb/sim_puf_qfilter.sv
module sim_puf_qfilter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        raw_valid = 1'b0;
    logic [31:0] raw_word = '0;
    logic        otp_rd_valid = 1'b0;
    logic        otp_rd_flag = 1'b0;
    logic [15:0] otp_rd_map = '0;
    logic        rd_en0, wr_en0, wr_flag0, done0;
    logic [15:0] wr_map0, key0;
    logic        rd_en1, wr_en1, wr_flag1, done1;
    logic [15:0] wr_map1, key1;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    puf_qfilter #(.FIX_ONE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .raw_valid(raw_valid), .raw_word(raw_word),
        .otp_rd_en(rd_en0), .otp_rd_valid(otp_rd_valid), .otp_rd_flag(otp_rd_flag),
        .otp_rd_map(otp_rd_map), .otp_wr_en(wr_en0), .otp_wr_flag(wr_flag0),
        .otp_wr_map(wr_map0), .key_out(key0), .key_done(done0));

    puf_qfilter #(.FIX_ONE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start), .raw_valid(raw_valid), .raw_word(raw_word),
        .otp_rd_en(rd_en1), .otp_rd_valid(otp_rd_valid), .otp_rd_flag(otp_rd_flag),
        .otp_rd_map(otp_rd_map), .otp_wr_en(wr_en1), .otp_wr_flag(wr_flag1),
        .otp_wr_map(wr_map1), .key_out(key1), .key_done(done1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FIX FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<5000", cyc);
            finish_run();
        end
    end

    task automatic run_case(input string tag, input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2, input logic [31:0] w3, input int otp_cyc,
                            input logic sflag, input logic [15:0] smap, input bit gap,
                            input bit restart, output logic [15:0] learned);
        logic [31:0] wd [4];
        logic [15:0] ekey, evmap, mask;
        logic [15:0] k0, k1, wmap;
        int rd_n, wr_n, dn_n, wr_c, dn_c, last, wflag;
        wd[0] = w0; wd[1] = w1; wd[2] = w2; wd[3] = w3;
        for (int i = 0; i < 16; i++) begin
            int wt;
            wt = $countones(wd[i / 4][(i % 4) * 8 +: 8]);
            ekey[i]  = (wt >= 4);
            evmap[i] = (wt >= 3) && (wt <= 5);
        end
        mask = sflag ? smap : evmap;
        last = gap ? 5 : 4;
        rd_n = 0; wr_n = 0; dn_n = 0; wr_c = -1; dn_c = -1; wflag = 0;
        k0 = '0; k1 = '0; wmap = '0;
        for (int c = 0; c < 16; c++) begin
            int widx;
            @(negedge clk);
            widx = -1;
            if (gap) begin
                if (c == 1) widx = 0;
                if (c == 2) widx = 1;
                if (c == 4) widx = 2;
                if (c == 5) widx = 3;
            end else if (c >= 1 && c <= 4) begin
                widx = c - 1;
            end
            start = (c == 0) || (restart && c == 2);
            if (widx >= 0) begin
                raw_valid = 1'b1; raw_word = wd[widx];
            end else if (c == 0 || c == last + 3) begin
                raw_valid = 1'b1; raw_word = 32'hFFFF_FFFF;
            end else begin
                raw_valid = 1'b0; raw_word = '0;
            end
            otp_rd_valid = (c == otp_cyc);
            otp_rd_flag  = sflag;
            otp_rd_map   = smap;
            #1;
            if (rd_en0) rd_n++;
            if (wr_en0) begin
                wr_n++; wr_c = c; wmap = wr_map0; wflag = int'(wr_flag0);
            end
            if (done0) begin
                dn_n++; dn_c = c; k0 = key0; k1 = key1;
            end
        end
        start = 1'b0; raw_valid = 1'b0; otp_rd_valid = 1'b0;
        chk({tag, " R10 single read request"}, rd_n, 1);
        chk({tag, " R8 one done pulse"}, dn_n, 1);
        chk({tag, " R8 done timing"}, dn_c, ((last > otp_cyc) ? last : otp_cyc) + 2);
        if (!sflag) begin
            chk({tag, " R5 one write"}, wr_n, 1);
            chk({tag, " R4 R5 written map"}, wmap, evmap);
            chk({tag, " R5 write flag"}, wflag, 1);
            chk({tag, " R5 write before done"}, wr_c, dn_c - 1);
        end else begin
            chk({tag, " R6 no write"}, wr_n, 0);
        end
        chk({tag, " R2 R3 R7 key fix0"}, k0, ekey & ~mask);
        chk({tag, " R7 key fix1"}, k1, ekey | mask);
        chk({tag, " R9 key held"}, key0, k0);
        learned = evmap;
    endtask

    initial begin
        logic [15:0] learned, dummy;
        repeat (3) @(negedge clk);
        chk("R1 key_out reset", key0, 0);
        chk("R1 key_done reset", done0, 0);
        chk("R1 strobes reset", {rd_en0, wr_en0}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {key0, done0, rd_en0, wr_en0}, 0);
        // first power-up, mixed weights around the threshold
        run_case("first", 32'h0F3F_0703, 32'hFF00_1F01, 32'hA55A_F07F, 32'h8001_C0FE,
                 1, 1'b0, 16'h0000, 1'b0, 1'b0, learned);
        // later power-up: stored map applied to different raw data
        run_case("later", 32'h0000_0000, 32'hFFFF_FFFF, 32'h0707_0707, 32'h1F1F_1F1F,
                 2, 1'b1, learned, 1'b0, 1'b0, dummy);
        // late OTP answer, gap in the raw words, extra start while busy
        run_case("late", 32'h3C3C_0301, 32'h7FFE_0F1E, 32'h0103_070F, 32'h1F3F_7FFF,
                 8, 1'b0, 16'hFFFF, 1'b1, 1'b1, dummy);
        // extremes: no volatile positions
        run_case("flat", 32'h0000_0000, 32'hFFFF_FFFF, 32'h00FF_00FF, 32'hFF00_FF00,
                 3, 1'b0, 16'h0000, 1'b0, 1'b0, dummy);
        finish_run();
    end
endmodule